// File: doc/BRIEF.md
# Local Bus Block Transfer Controller

This peripheral moves a block of bytes between an internal word FIFO and an external local bus. Software programs a start address, a chip-select number, a direction and a byte count, then launches the transfer with a single-byte write. In the outbound direction the host (or a DMA engine answering the request line) feeds 32-bit words into the FIFO through a data port, and a bus sequencer drains them to the external bus. In the inbound direction the sequencer reads words from the external bus into the FIFO, and the host drains them through the same data port.

The byte count can be far larger than the FIFO, so a DMA request line keeps the FIFO supplied, with the trip level set by a watermark register. The FIFO itself never interrupts. The only interrupt sources are the completion flag and the abort flag, each with its own enable and both gated by a master enable. The abort flag is raised by any data-port access the FIFO or the running direction cannot honour, and it stops the transfer. Registers are 32 bits wide and big-endian: byte enable bit 3 selects bits 31:24, which sit at the lowest byte address of each register.

Top module: `lbus_xfer_ctrl`

## Requirements
- R1: After reset every register reads zero, except the FIFO status register, which reads 0x0001_0000 (empty bit 16 set, nothing else). The interrupt and DMA request outputs are low.
- R2: Registers decode by byte address: size 0x00 (bits 23:0), start address 0x04, control 0x08 (chip select 31:24, inbound direction bit 16, fixed configuration bit 3), enable 0x0C, status 0x14, data port 0x40, FIFO status 0x44, FIFO granularity 0x48 (bits 26:24), watermark 0x4C (bits 9:0). Only the bytes whose enable bits are set are written, and unused bits read zero.
- R3: The FIFO holds 128 words in first-in first-out order. FIFO status bits 15:0 give the fill in bytes, bit 16 flags empty and bit 17 flags full.
- R4: A data-port write while the FIFO is full, or a read while it is empty, is ignored and sets the sticky abort flag (status bit 28). An ignored read returns zero.
- R5: A write to the size register with byte enable 3 set and byte value 0x01 in bits 31:24 starts a transfer, but only when the master enable (enable bit 0) is set and both reset bits are clear. Any other value in that byte starts nothing.
- R6: An outbound transfer (control bit 16 = 0) drives ext_we high, presents FIFO words in order, and places the first at the start address and each later one 4 bytes higher, all on the programmed chip select.
- R7: An inbound transfer (control bit 16 = 1) reads the same address sequence with ext_we low and pushes each returned word into the FIFO in order.
- R8: Status bits 23:0 count the bytes moved. The final word counts only the bytes still remaining. When the count equals the size, the complete flag (status bit 24) is set and bus activity ends. A size of zero completes at once.
- R9: irq is high exactly when the master enable is set and either complete with the completion enable (bit 8) is set, or abort with the error enable (bit 9) is set. Writing 1 to status bit 24 clears complete, and writing 1 to bit 28 clears abort.
- R10: Enable bit 24 held at 1 stops the transfer and clears both flags and the byte count, but keeps the FIFO contents. Enable bit 16 held at 1 empties the FIFO.
- R11: During an outbound transfer dma_req is high while the FIFO fill in bytes is at most the watermark. During an inbound transfer it is high while the fill is non-zero and fill plus watermark is at least 512. When no transfer is running it is low.
- R12: A bus beat completes only in a cycle with ext_ack high. Until that cycle, address and chip select hold steady.
- R13: While an inbound transfer runs, a host data-port write is ignored. While an outbound transfer runs, a host data-port read is ignored. Either one sets abort and stops the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at the data port) |
| reg_addr | input | 8 | Register byte address |
| reg_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ext_req | output | 1 | External bus beat request |
| ext_we | output | 1 | 1 = write to external bus |
| ext_cs | output | 8 | Chip-select number |
| ext_addr | output | 32 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| ext_ack | input | 1 | Beat accepted this cycle |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt |

## Verification
A corrupted byte counter shows up in the status count, and a corrupted size compare shows up in the number of bus beats. Both are visible on the cycle after the last beat, when the complete flag either appears or fails to appear. A bad FIFO pointer shows up as wrong word order at the data port or on ext_wdata within one access. A lost or stuck flag shows up on irq in the cycle after its event, because irq is a plain combination of the flag and enable registers. Address stepping and hold under wait states are visible on ext_addr at every beat.

// File: rtl/lbus_xfer_pkg.sv
package lbus_xfer_pkg;
   localparam logic [7:0] A_SIZE  = 8'h00;
   localparam logic [7:0] A_BASE  = 8'h04;
   localparam logic [7:0] A_CTRL  = 8'h08;
   localparam logic [7:0] A_ENAB  = 8'h0C;
   localparam logic [7:0] A_STAT  = 8'h14;
   localparam logic [7:0] A_DATA  = 8'h40;
   localparam logic [7:0] A_FSTAT = 8'h44;
   localparam logic [7:0] A_FGRAN = 8'h48;
   localparam logic [7:0] A_ALARM = 8'h4C;

   // merge a register image with new data under big-endian byte enables
   function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                            input logic [31:0] nw,
                                            input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : cur[b*8 +: 8];
      return r;
   endfunction
endpackage

// File: rtl/lbus_word_fifo.sv
module lbus_word_fifo #(
   parameter int unsigned WORDS  = 128,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned AW    = $clog2(WORDS),
   localparam int unsigned CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty
);
   initial assert (WORDS >= 2) else $fatal(1, "lbus_word_fifo: WORDS must be at least 2");

   logic [DATA_W-1:0] mem [WORDS];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic push_ok, pop_ok;

   assign full    = (count == CW'(WORDS));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((1 << AW) == WORDS) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(WORDS - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(WORDS - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3: a push into a full FIFO without a pop leaves the fill unchanged
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));
   // R4: a pop from an empty FIFO without a push leaves it empty
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CS_W   = 8,
   localparam int unsigned BEAT  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              clr,
   input  logic              start,
   input  logic              dir_rd_in,
   input  logic [CS_W-1:0]   cs_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [CNT_W-1:0]  size_in,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic [DATA_W-1:0] fifo_head,
   output logic              fifo_pop,
   output logic              fifo_push,
   output logic              ext_req,
   output logic              ext_we,
   output logic [CS_W-1:0]   ext_cs,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic              ext_ack,
   output logic              busy,
   output logic              run_rd,
   output logic [CNT_W-1:0]  bytes_done,
   output logic              done_evt
);
   logic [CNT_W-1:0] size_q, cnt_q, remain, step;
   logic at_end, beat;

   assign remain     = size_q - cnt_q;
   assign step       = (remain < CNT_W'(BEAT)) ? remain : CNT_W'(BEAT);
   assign at_end     = (cnt_q == size_q);
   assign ext_req    = busy && !at_end && !stop && (run_rd ? !fifo_full : !fifo_empty);
   assign beat       = ext_req && ext_ack;
   assign ext_we     = !run_rd;
   assign ext_wdata  = fifo_head;
   assign fifo_pop   = beat && !run_rd;
   assign fifo_push  = beat && run_rd;
   assign bytes_done = cnt_q;
   assign done_evt   = busy && at_end && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         run_rd   <= 1'b0;
         ext_cs   <= '0;
         ext_addr <= '0;
         size_q   <= '0;
         cnt_q    <= '0;
      end else if (stop) begin
         busy <= 1'b0;
         if (clr) cnt_q <= '0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         run_rd   <= dir_rd_in;
         ext_cs   <= cs_in;
         ext_addr <= base_in;
         size_q   <= size_in;
         cnt_q    <= '0;
      end else if (busy) begin
         if (at_end) begin
            busy <= 1'b0;
         end else if (beat) begin
            ext_addr <= ext_addr + ADDR_W'(BEAT);
            cnt_q    <= cnt_q + step;
         end
      end
   end

   // R12: an unacknowledged request keeps address and chip select
   p_wait_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_addr == $past(ext_addr) && ext_cs == $past(ext_cs)));
   // R6: each accepted beat advances the address by one word
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && ext_ack) |=> (ext_addr == $past(ext_addr) + ADDR_W'(BEAT)));
   // R8: the byte count never passes the programmed size while running
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= size_q));
endmodule

// File: rtl/lbus_xfer_ctrl.sv
module lbus_xfer_ctrl
   import lbus_xfer_pkg::*;
#(
   parameter int unsigned FIFO_WORDS = 128,
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned ADDR_W     = 32,
   localparam int unsigned FIFO_B    = FIFO_WORDS * 4,
   localparam int unsigned LVL_W     = $clog2(FIFO_WORDS) + 3,
   localparam int unsigned FCW       = $clog2(FIFO_WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [3:0]        reg_be,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ext_req,
   output logic              ext_we,
   output logic [7:0]        ext_cs,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [31:0]       ext_wdata,
   input  logic [31:0]       ext_rdata,
   input  logic              ext_ack,
   output logic              dma_req,
   output logic              irq
);
   initial assert (CNT_W >= 3 && CNT_W <= 24) else $fatal(1, "lbus_xfer_ctrl: CNT_W out of range");
   initial assert (ADDR_W >= 8 && ADDR_W <= 32) else $fatal(1, "lbus_xfer_ctrl: ADDR_W out of range");
   initial assert (LVL_W <= 16) else $fatal(1, "lbus_xfer_ctrl: FIFO too deep for status field");

   // programmed state
   logic [CNT_W-1:0]  size_q;
   logic [ADDR_W-1:0] base_q;
   logic [7:0]        cs_q;
   logic              dir_rd_q, cfg_q;
   logic              rst_x_q, rst_f_q, eie_q, cie_q, men_q;
   logic [2:0]        gran_q;
   logic [LVL_W-1:0]  alarm_q;
   logic              cmp_q, abt_q;

   // datapath links
   logic              f_push, f_pop, f_full, f_empty;
   logic [31:0]       f_head, f_wdata;
   logic [FCW-1:0]    f_count;
   logic [LVL_W-1:0]  occ;
   logic              s_busy, s_run_rd, s_done, s_pop, s_push;
   logic [CNT_W-1:0]  s_bytes;

   logic        wr_data, rd_data, bad_push, bad_pop, start, stop;
   logic [31:0] img_size, img_base, img_ctrl, img_enab, img_gran, img_alarm, cur_ctrl, cur_enab;

   assign occ      = {f_count, 2'b00};
   assign wr_data  = reg_wr && reg_addr == A_DATA;
   assign rd_data  = reg_rd && reg_addr == A_DATA;
   assign bad_push = wr_data && (f_full || (s_busy && s_run_rd));
   assign bad_pop  = rd_data && (f_empty || (s_busy && !s_run_rd));
   assign start    = reg_wr && reg_addr == A_SIZE && reg_be[3] && reg_wdata[31:24] == 8'h01
                     && men_q && !rst_x_q && !rst_f_q;
   assign stop     = rst_x_q || bad_push || bad_pop;

   assign cur_ctrl  = {cs_q, 7'b0, dir_rd_q, 12'b0, cfg_q, 3'b0};
   assign cur_enab  = {7'b0, rst_x_q, 7'b0, rst_f_q, 6'b0, eie_q, cie_q, 7'b0, men_q};
   assign img_size  = be_merge(32'(size_q), reg_wdata, reg_be);
   assign img_base  = be_merge(32'(base_q), reg_wdata, reg_be);
   assign img_ctrl  = be_merge(cur_ctrl, reg_wdata, reg_be);
   assign img_enab  = be_merge(cur_enab, reg_wdata, reg_be);
   assign img_gran  = be_merge({5'b0, gran_q, 24'b0}, reg_wdata, reg_be);
   assign img_alarm = be_merge(32'(alarm_q), reg_wdata, reg_be);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q  <= '0;  base_q  <= '0;  cs_q  <= '0;  dir_rd_q <= 1'b0; cfg_q <= 1'b0;
         rst_x_q <= 1'b0; rst_f_q <= 1'b0; eie_q <= 1'b0; cie_q <= 1'b0; men_q <= 1'b0;
         gran_q  <= '0;  alarm_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_SIZE:  size_q  <= img_size[CNT_W-1:0];
            A_BASE:  base_q  <= img_base[ADDR_W-1:0];
            A_CTRL:  begin
               cs_q <= img_ctrl[31:24]; dir_rd_q <= img_ctrl[16]; cfg_q <= img_ctrl[3];
            end
            A_ENAB:  begin
               rst_x_q <= img_enab[24]; rst_f_q <= img_enab[16];
               eie_q <= img_enab[9]; cie_q <= img_enab[8]; men_q <= img_enab[0];
            end
            A_FGRAN: gran_q  <= img_gran[26:24];
            A_ALARM: alarm_q <= img_alarm[LVL_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= 1'b0;
         abt_q <= 1'b0;
      end else if (rst_x_q) begin
         cmp_q <= 1'b0;
         abt_q <= 1'b0;
      end else begin
         if (s_done) cmp_q <= 1'b1;
         else if (reg_wr && reg_addr == A_STAT && reg_be[3] && reg_wdata[24]) cmp_q <= 1'b0;
         if (bad_push || bad_pop) abt_q <= 1'b1;
         else if (reg_wr && reg_addr == A_STAT && reg_be[3] && reg_wdata[28]) abt_q <= 1'b0;
      end
   end

   assign f_push  = (wr_data && !bad_push) || s_push;
   assign f_pop   = (rd_data && !bad_pop) || s_pop;
   assign f_wdata = s_push ? ext_rdata : reg_wdata;

   lbus_word_fifo #(.WORDS(FIFO_WORDS), .DATA_W(32)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rst_f_q), .push(f_push), .wdata(f_wdata),
      .pop(f_pop), .head(f_head), .count(f_count), .full(f_full), .empty(f_empty));

   lbus_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(32), .CS_W(8)) u_seq (
      .clk(clk), .rst_n(rst_n), .stop(stop), .clr(rst_x_q), .start(start),
      .dir_rd_in(dir_rd_q), .cs_in(cs_q), .base_in(base_q), .size_in(img_size[CNT_W-1:0]),
      .fifo_empty(f_empty), .fifo_full(f_full), .fifo_head(f_head),
      .fifo_pop(s_pop), .fifo_push(s_push),
      .ext_req(ext_req), .ext_we(ext_we), .ext_cs(ext_cs), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_ack(ext_ack),
      .busy(s_busy), .run_rd(s_run_rd), .bytes_done(s_bytes), .done_evt(s_done));

   assign irq = men_q && ((cmp_q && cie_q) || (abt_q && eie_q));

   always_comb begin
      dma_req = 1'b0;
      if (s_busy && !s_run_rd)
         dma_req = (occ <= alarm_q);
      else if (s_busy && s_run_rd)
         dma_req = (occ != '0) && (({1'b0, occ} + {1'b0, alarm_q}) >= (LVL_W + 1)'(FIFO_B));
   end

   always_comb begin
      case (reg_addr)
         A_SIZE:  reg_rdata = 32'(size_q);
         A_BASE:  reg_rdata = 32'(base_q);
         A_CTRL:  reg_rdata = cur_ctrl;
         A_ENAB:  reg_rdata = cur_enab;
         A_STAT:  reg_rdata = {3'b0, abt_q, 3'b0, cmp_q, 24'(s_bytes)};
         A_DATA:  reg_rdata = (f_empty || (s_busy && !s_run_rd)) ? 32'h0 : f_head;
         A_FSTAT: reg_rdata = {14'b0, f_full, f_empty, 16'(occ)};
         A_FGRAN: reg_rdata = {5'b0, gran_q, 24'b0};
         A_ALARM: reg_rdata = 32'(alarm_q);
         default: reg_rdata = 32'h0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{img_size, img_base, img_ctrl, img_enab, img_gran, img_alarm};

   // R4: abort stays set until cleared by software or the transfer reset
   p_abt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (abt_q && !rst_x_q && !(reg_wr && reg_addr == A_STAT)) |=> abt_q);
   // R8: completion is only flagged by a transfer that was running
   p_cmp_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_q) |-> ($past(s_busy) && !s_busy));
   // R13: an illegal data-port access ends bus activity on the next cycle
   p_abort_stops_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_push || bad_pop) |=> !ext_req);
endmodule

// File: tb/lbus_xfer_ctrl_test.sv
module lbus_xfer_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_addr = 0;
   logic [3:0] reg_be = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic ext_req, ext_we, dma_req, irq;
   logic [7:0] ext_cs;
   logic [31:0] ext_addr, ext_wdata, ext_rdata;
   logic ack_en = 1'b1, ack_slow = 1'b0, tog = 1'b0;
   logic ext_ack;

   int n_chk = 0, n_fail = 0, n_tx = 0;
   logic [31:0] tx_addr [64];
   logic [31:0] tx_data [64];
   logic [7:0]  tx_cs   [64];
   logic        tx_we   [64];
   logic done_flag = 1'b0;

   always #5 clk = ~clk;

   assign ext_rdata = ext_addr ^ 32'h5A00_00C3;
   assign ext_ack   = ack_en && (!ack_slow || tog);

   lbus_xfer_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_cs(ext_cs), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
      .dma_req(dma_req), .irq(irq));

   always @(posedge clk) begin
      tog <= ~tog;
      if (ext_req && ext_ack && n_tx < 64) begin
         tx_addr[n_tx] <= ext_addr;
         tx_data[n_tx] <= ext_wdata;
         tx_cs[n_tx]   <= ext_cs;
         tx_we[n_tx]   <= ext_we;
         n_tx <= n_tx + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 0; reg_be = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_end(output logic [31:0] st);
      st = 0;
      for (int i = 0; i < 400; i++) begin
         peek(8'h14, st);
         if (st[24] || st[28]) break;
      end
   endtask

   task automatic ack_pulse();
      @(negedge clk); ack_en = 1;
      @(negedge clk); ack_en = 0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int base_tx;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      peek(8'h0C, v); chk("R1 enable reset", v, 32'h0);
      peek(8'h14, v); chk("R1 status reset", v, 32'h0);
      peek(8'h44, v); chk("R1 fifo status reset", v, 32'h0001_0000);
      peek(8'h08, v); chk("R1 control reset", v, 32'h0);
      chk("R1 irq reset", {31'b0, irq}, 32'h0);
      chk("R1 dma_req reset", {31'b0, dma_req}, 32'h0);

      // R2 register decode and byte enables
      wr(8'h04, 32'h1234_5678, 4'hF);
      wr(8'h04, 32'hAB00_0000, 4'h8);
      peek(8'h04, v); chk("R2 byte-lane write", v, 32'hAB34_5678);
      wr(8'h08, 32'hFFFF_FFFF, 4'hF);
      peek(8'h08, v); chk("R2 control fields", v, 32'hFF01_0008);
      wr(8'h4C, 32'hFFFF_FFFF, 4'hF);
      peek(8'h4C, v); chk("R2 watermark width", v, 32'h0000_03FF);
      wr(8'h48, 32'h0700_0000, 4'h8);
      peek(8'h48, v); chk("R2 granularity", v, 32'h0700_0000);
      wr(8'h00, 32'hFF00_1234, 4'hF);
      peek(8'h00, v); chk("R2 size width", v, 32'h0000_1234);
      peek(8'h14, v); chk("R5 bad start byte no run", v, 32'h0);

      // R3 fill to full, R4 overflow
      for (int i = 0; i < 128; i++) wr(8'h40, i * 3 + 1, 4'hF);
      peek(8'h44, v); chk("R3 full status", v, 32'h0002_0200);
      wr(8'h40, 32'hDEAD_BEEF, 4'hF);
      peek(8'h44, v); chk("R4 push on full ignored", v, 32'h0002_0200);
      peek(8'h14, v); chk("R4 abort on overflow", v, 32'h1000_0000);
      for (int i = 0; i < 128; i++) begin
         rd(8'h40, v); chk("R3 fifo order", v, i * 3 + 1);
      end
      peek(8'h44, v); chk("R3 empty status", v, 32'h0001_0000);
      rd(8'h40, v); chk("R4 pop on empty returns zero", v, 32'h0);
      wr(8'h14, 32'h1000_0000, 4'h8);
      peek(8'h14, v); chk("R9 abort w1c", v, 32'h0);

      // R5/R6/R8/R12 outbound with wait states
      wr(8'h0C, 32'h0000_0301, 4'hF);
      wr(8'h08, 32'h0500_0008, 4'hF);
      wr(8'h04, 32'h0000_0100, 4'hF);
      for (int i = 0; i < 3; i++) wr(8'h40, 32'hC000_0000 + i, 4'hF);
      wr(8'h00, 32'h0000_000A, 4'h7);
      base_tx = n_tx;
      wr(8'h00, 32'h0200_0000, 4'h8);
      repeat (4) @(negedge clk);
      peek(8'h44, v); chk("R5 value 0x02 does not start", v, 32'h0000_000C);
      chk("R5 no bus beats", n_tx - base_tx, 0);
      ack_slow = 1;
      wr(8'h00, 32'h0100_0000, 4'h8);
      wait_end(v);
      chk("R8 partial count and complete", v, 32'h0100_000A);
      chk("R6 beat count", n_tx - base_tx, 3);
      for (int i = 0; i < 3; i++) begin
         chk("R6 address step", tx_addr[base_tx + i], 32'h100 + 4 * i);
         chk("R6 data order", tx_data[base_tx + i], 32'hC000_0000 + i);
         chk("R6 chip select", {24'b0, tx_cs[base_tx + i]}, 32'h5);
         chk("R6 write strobe", {31'b0, tx_we[base_tx + i]}, 32'h1);
      end
      ack_slow = 0;
      chk("R9 irq on complete", {31'b0, irq}, 32'h1);
      wr(8'h14, 32'h0100_0000, 4'h8);
      peek(8'h14, v); chk("R9 complete w1c", v, 32'h0000_000A);
      chk("R9 irq cleared", {31'b0, irq}, 32'h0);

      // R7 inbound
      wr(8'h08, 32'h0201_0008, 4'hF);
      wr(8'h04, 32'h0000_0200, 4'hF);
      base_tx = n_tx;
      wr(8'h00, 32'h0100_0010, 4'hF);
      wait_end(v);
      chk("R7 inbound complete", v, 32'h0100_0010);
      peek(8'h44, v); chk("R7 fifo fill", v, 32'h0000_0010);
      chk("R7 read strobe", {31'b0, tx_we[base_tx]}, 32'h0);
      chk("R7 chip select", {24'b0, tx_cs[base_tx]}, 32'h2);
      chk("R11 no request when idle", {31'b0, dma_req}, 32'h0);
      for (int i = 0; i < 4; i++) begin
         rd(8'h40, v); chk("R7 inbound data", v, (32'h200 + 4 * i) ^ 32'h5A00_00C3);
      end
      wr(8'h14, 32'h0100_0000, 4'h8);

      // R8 zero size
      wr(8'h08, 32'h0000_0008, 4'hF);
      base_tx = n_tx;
      wr(8'h00, 32'h0100_0000, 4'hF);
      wait_end(v);
      chk("R8 zero size completes", v, 32'h0100_0000);
      chk("R8 zero size no beats", n_tx - base_tx, 0);

      // R9 gating
      wr(8'h0C, 32'h0000_0201, 4'hF);
      peek(8'h0C, v);
      chk("R9 completion enable off", {31'b0, irq}, 32'h0);
      wr(8'h0C, 32'h0000_0101, 4'hF);
      peek(8'h0C, v);
      chk("R9 completion enable on", {31'b0, irq}, 32'h1);
      wr(8'h0C, 32'h0000_0100, 4'hF);
      peek(8'h0C, v);
      chk("R9 master enable gates", {31'b0, irq}, 32'h0);
      wr(8'h0C, 32'h0000_0301, 4'hF);
      wr(8'h14, 32'h0100_0000, 4'h8);

      // R11 outbound request, R10 reset bits
      ack_en = 0;
      wr(8'h4C, 32'h0000_0004, 4'hF);
      wr(8'h00, 32'h0100_0040, 4'hF);
      peek(8'h44, v);
      chk("R11 outbound request low fill", {31'b0, dma_req}, 32'h1);
      wr(8'h40, 32'h1111_1111, 4'hF);
      wr(8'h40, 32'h2222_2222, 4'hF);
      peek(8'h44, v);
      chk("R11 outbound request above mark", {31'b0, dma_req}, 32'h0);
      wr(8'h0C, 32'h0100_0001, 4'hF);
      peek(8'h14, v); chk("R10 transfer reset clears status", v, 32'h0);
      peek(8'h44, v); chk("R10 transfer reset keeps fifo", v, 32'h0000_0008);
      base_tx = n_tx;
      ack_en = 1;
      repeat (4) @(negedge clk);
      chk("R10 stopped no beats", n_tx - base_tx, 0);
      wr(8'h0C, 32'h0001_0001, 4'hF);
      peek(8'h44, v); chk("R10 fifo reset empties", v, 32'h0001_0000);
      wr(8'h0C, 32'h0000_0301, 4'hF);

      // R11 inbound request
      ack_en = 0;
      wr(8'h08, 32'h0001_0008, 4'hF);
      wr(8'h4C, 32'h0000_01F8, 4'hF);
      wr(8'h00, 32'h0100_0040, 4'hF);
      peek(8'h44, v);
      chk("R11 inbound empty no request", {31'b0, dma_req}, 32'h0);
      ack_pulse();
      peek(8'h44, v); chk("R12 single acked beat", v, 32'h0000_0004);
      chk("R11 inbound below mark", {31'b0, dma_req}, 32'h0);
      ack_pulse();
      peek(8'h44, v);
      chk("R11 inbound at mark", {31'b0, dma_req}, 32'h1);

      // R13 host write during inbound run
      wr(8'h40, 32'h7777_7777, 4'hF);
      peek(8'h14, v); chk("R13 abort and count kept", v, 32'h1000_0008);
      peek(8'h44, v); chk("R13 write ignored", v, 32'h0000_0008);
      chk("R13 abort raises irq", {31'b0, irq}, 32'h1);
      base_tx = n_tx;
      ack_en = 1;
      repeat (4) @(negedge clk);
      chk("R13 transfer stopped", n_tx - base_tx, 0);

      finish_run();
   end
endmodule